// File: doc/BRIEF.md
# Dual-Context Serial Configuration Store

This block keeps two full configuration images for one region of a reconfigurable fabric. One image, the active context, drives a parallel configuration bus. The other, the shadow context, is filled in the background one bit at a time through a scan chain. When the shadow image is complete, a switch request swaps the roles of the two images in a single clock edge. This lets a new configuration be staged while the old one keeps running.

The serial input is a one-bit valid/ready stream. A bit is taken on a rising edge only when `sin_valid` and `sin_ready` are both high. `sin_ready` is a combinational function of the control inputs: it drops in any cycle where `sw_req` or `ld_clr` is high. A source that has a bit waiting must hold it, with `sin_valid` high, until it sees ready. A bit counter tracks how many bits have entered since the last accepted switch or clear. A switch is only allowed when that count is exactly the configuration width. A switch at any other count is refused and flagged as an error.

Top module: `dual_ctx_cfg_store`

## Requirements
- R1: After reset, both contexts hold all zeros and context 0 is active. In that state `cfg_out` is zero, `active_ctx` is 0, `shadow_ctx` is 1, `loaded` is 0, `sw_err` is 0 and `sin_ready` is 1.
- R2: `cfg_out` keeps its value in every cycle without an accepted switch, whatever bits are shifted in. Shifting only ever changes the shadow context.
- R3: Each accepted bit enters the shadow context at bit position CFG_BITS-1, and the earlier contents move one position toward bit 0. After CFG_BITS accepted bits, the first bit sent sits at position 0 and the last at position CFG_BITS-1.
- R4: A switch request while `loaded` is high is accepted. On that clock edge `active_ctx` flips, `shadow_ctx` becomes its complement, and `cfg_out` shows the former shadow contents from the next cycle.
- R5: A switch request while `loaded` is low is refused. The active context is kept, and `sw_err` is high from the next cycle. `sw_err` stays high until an accepted switch or a clear.
- R6: `loaded` is high exactly when the count of accepted bits since the last accepted switch or clear equals CFG_BITS. One bit fewer or one bit more leaves it low.
- R7: An accepted switch resets the bit count, so `loaded` is low afterwards. A second switch request straight after an accepted one is refused.
- R8: `ld_clr` without `sw_req` resets the bit count and clears `sw_err`. It leaves both contexts unchanged.
- R9: `sin_ready` is low in any cycle with `sw_req` or `ld_clr` high. An offered bit is not taken in that cycle. `sw_req` takes priority over `ld_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sin_valid | input | 1 | A serial configuration bit is offered |
| sin_bit | input | 1 | Serial configuration bit |
| sin_ready | output | 1 | The store can take a bit this cycle |
| ld_clr | input | 1 | Restart the bit count and clear the error flag |
| sw_req | input | 1 | Request to swap the active and shadow contexts |
| loaded | output | 1 | Exactly CFG_BITS bits have arrived since the last switch or clear |
| sw_err | output | 1 | A switch was refused (sticky) |
| active_ctx | output | 1 | Index of the context driving `cfg_out` |
| shadow_ctx | output | 1 | Index of the context the scan chain writes |
| cfg_out | output | CFG_BITS | Configuration bus driven from the active context |

## Verification
The bench targets the count boundary by sending CFG_BITS-1, CFG_BITS and CFG_BITS+1 bits before a switch. A counter that is off by one, or that does not saturate, would accept a short or overlong load. It switches twice back to back; a design that did not reset the count on a switch would swap stale data back in. It also drives a switch and a clear together while offering a bit. A design without the correct priority would take the bit, or would clear the error that the refused switch should raise. It loads a known asymmetric word and compares the bus after the switch, which catches a reversed scan direction. Throughout, it watches that the live bus never moves while bits are shifting, which would reveal shifting into the wrong context.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

  typedef enum logic {
    CTX_ZERO = 1'b0,
    CTX_ONE  = 1'b1
  } ctx_id_e;

  function automatic ctx_id_e other_ctx(input ctx_id_e c);
    return (c == CTX_ZERO) ? CTX_ONE : CTX_ZERO;
  endfunction

endpackage

// File: rtl/cfg_scan_ctx.sv
module cfg_scan_ctx #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);

  generate
    if (W == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (shift_en) q <= {din, q[W-1:1]};
      end
    end
  endgenerate

  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q)); // R2

endmodule

// File: rtl/cfg_load_tracker.sv
module cfg_load_tracker #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic take,
  output logic loaded
);

  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(W + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (restart)              cnt <= '0;
    else if (take && cnt != OVER)  cnt <= cnt + 1'b1;
  end

  assign loaded = (cnt == FULL);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVER); // R6
  AST_RESTART_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !loaded); // R7

endmodule

// File: rtl/cfg_switch_ctrl.sv
module cfg_switch_ctrl
  import cfgmem_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sw_req,
  input  logic    clr,
  input  logic    loaded,
  output ctx_id_e active,
  output logic    accept,
  output logic    err
);

  assign accept = sw_req & loaded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= CTX_ZERO;
      err    <= 1'b0;
    end else if (sw_req) begin
      if (loaded) active <= other_ctx(active);
      err <= ~loaded;
    end else if (clr) begin
      err <= 1'b0;
    end
  end

  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && !loaded) |=> ($stable(active) && err)); // R5
  AST_ACCEPT_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && loaded) |=> (active != $past(active) && !err)); // R4

endmodule

// File: rtl/dual_ctx_cfg_store.sv
module dual_ctx_cfg_store
  import cfgmem_pkg::*;
#(
  parameter int CFG_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sin_valid,
  input  logic                sin_bit,
  output logic                sin_ready,
  input  logic                ld_clr,
  input  logic                sw_req,
  output logic                loaded,
  output logic                sw_err,
  output logic                active_ctx,
  output logic                shadow_ctx,
  output logic [CFG_BITS-1:0] cfg_out
);

  localparam int NCTX = 2;

  ctx_id_e             act_q;
  ctx_id_e             shd;
  logic                take;
  logic                accept;
  logic                restart;
  logic [CFG_BITS-1:0] ctx_q [NCTX];

  assign sin_ready = ~sw_req & ~ld_clr;
  assign take      = sin_valid & sin_ready;
  assign shd       = other_ctx(act_q);
  assign restart   = accept | (ld_clr & ~sw_req);

  genvar g;
  generate
    for (g = 0; g < NCTX; g++) begin : g_ctx
      logic sel;
      assign sel = take && (shd == ctx_id_e'(g));
      cfg_scan_ctx #(.W(CFG_BITS)) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sel),
        .din      (sin_bit),
        .q        (ctx_q[g])
      );
    end
  endgenerate

  cfg_load_tracker #(.W(CFG_BITS)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .take    (take),
    .loaded  (loaded)
  );

  cfg_switch_ctrl u_sw (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_req (sw_req),
    .clr    (ld_clr),
    .loaded (loaded),
    .active (act_q),
    .accept (accept),
    .err    (sw_err)
  );

  assign active_ctx = logic'(act_q);
  assign shadow_ctx = logic'(shd);
  assign cfg_out    = ctx_q[act_q];

  AST_LIVE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_req |=> $stable(cfg_out)); // R2
  AST_SWITCH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req || ld_clr) |-> !sin_ready); // R9
  AST_ACCEPT_UNLOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && loaded) |=> !loaded); // R7
  AST_ROLES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    active_ctx != shadow_ctx); // R4
  AST_CLEAR_UNLOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_clr && !sw_req) |=> (!loaded && !sw_err)); // R8

endmodule

// File: tb/sim_dual_ctx_cfg_store.sv
`timescale 1ns/1ps
module sim_dual_ctx_cfg_store;

  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sin_valid = 1'b0;
  logic         sin_bit = 1'b0;
  logic         sin_ready;
  logic         ld_clr = 1'b0;
  logic         sw_req = 1'b0;
  logic         loaded;
  logic         sw_err;
  logic         active_ctx;
  logic         shadow_ctx;
  logic [N-1:0] cfg_out;

  int n_chk = 0;
  int n_bad = 0;

  logic [N-1:0] m_ctx [2];
  int           m_act;
  int           m_cnt;
  bit           m_err;

  always #4 clk = ~clk;

  dual_ctx_cfg_store #(.CFG_BITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .sin_valid(sin_valid), .sin_bit(sin_bit),
    .sin_ready(sin_ready), .ld_clr(ld_clr), .sw_req(sw_req),
    .loaded(loaded), .sw_err(sw_err), .active_ctx(active_ctx),
    .shadow_ctx(shadow_ctx), .cfg_out(cfg_out)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] shifted(input logic [N-1:0] v, input logic b);
    return {b, v[N-1:1]};
  endfunction

  task automatic model_step(input bit v, input bit b, input bit s, input bit c);
    if (s) begin
      if (m_cnt == N) begin
        m_act = 1 - m_act;
        m_cnt = 0;
        m_err = 1'b0;
      end else begin
        m_err = 1'b1;
      end
    end else if (c) begin
      m_cnt = 0;
      m_err = 1'b0;
    end else if (v) begin
      m_ctx[1-m_act] = shifted(m_ctx[1-m_act], b);
      if (m_cnt != N + 1) m_cnt++;
    end
  endtask

  task automatic compare_all();
    check("R2/R4 cfg_out", 64'(cfg_out), 64'(m_ctx[m_act]));
    check("R4 active_ctx", 64'(active_ctx), 64'(m_act));
    check("R4 shadow_ctx", 64'(shadow_ctx), 64'(1 - m_act));
    check("R6 loaded", 64'(loaded), 64'(m_cnt == N));
    check("R5 sw_err", 64'(sw_err), 64'(m_err));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic cycle(input bit v, input bit b, input bit s, input bit c);
    sin_valid = v; sin_bit = b; sw_req = s; ld_clr = c;
    #1;
    check("R9 sin_ready", 64'(sin_ready), 64'(!s && !c));
    @(posedge clk);
    model_step(v, b, s, c);
    @(negedge clk);
    compare_all();
  endtask

  task automatic push_word(input logic [N-1:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) cycle(1'b1, w[i % N], 1'b0, 1'b0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    logic [N-1:0] prev;
    int seed;
    seed = $urandom(32'd4242);
    m_ctx[0] = '0; m_ctx[1] = '0; m_act = 0; m_cnt = 0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cfg_out", 64'(cfg_out), 64'd0);
    check("R1 active_ctx", 64'(active_ctx), 64'd0);
    check("R1 shadow_ctx", 64'(shadow_ctx), 64'd1);
    check("R1 loaded", 64'(loaded), 64'd0);
    check("R1 sw_err", 64'(sw_err), 64'd0);
    check("R1 sin_ready", 64'(sin_ready), 64'd1);

    // R6/R5: one bit short, switch refused
    pat = 32'hA5C3_0F71;
    push_word(pat, N - 1);
    check("R6 short load not loaded", 64'(loaded), 64'd0);
    cycle(1'b0, 1'b0, 1'b1, 1'b0);
    check("R5 short switch refused", 64'(active_ctx), 64'd0);
    check("R5 error raised", 64'(sw_err), 64'd1);

    // R8: clear resets count and error, contents kept
    cycle(1'b1, 1'b1, 1'b0, 1'b1);
    check("R8 clear drops error", 64'(sw_err), 64'd0);
    check("R8 clear keeps live bus", 64'(cfg_out), 64'd0);

    // R3/R4: exact load then accepted switch shows the word in order
    push_word(pat, N);
    check("R6 exact load", 64'(loaded), 64'd1);
    check("R2 live bus steady during load", 64'(cfg_out), 64'd0);
    cycle(1'b1, 1'b0, 1'b1, 1'b0);
    check("R3 scan order after switch", 64'(cfg_out), 64'(pat));
    check("R4 active flipped", 64'(active_ctx), 64'd1);

    // R7: immediate second switch refused
    cycle(1'b0, 1'b0, 1'b1, 1'b0);
    check("R7 back-to-back switch refused", 64'(active_ctx), 64'd1);
    check("R7 error after back-to-back", 64'(sw_err), 64'd1);

    // R6: one bit too many
    cycle(1'b0, 1'b0, 1'b0, 1'b1);
    push_word(~pat, N + 1);
    check("R6 overlong load not loaded", 64'(loaded), 64'd0);
    cycle(1'b0, 1'b0, 1'b1, 1'b0);
    check("R6 overlong switch refused", 64'(cfg_out), 64'(pat));

    // R9: switch and clear together with a bit offered; switch wins
    cycle(1'b0, 1'b0, 1'b0, 1'b1);
    prev = 32'h1357_9BDF;
    push_word(prev, N);
    cycle(1'b1, 1'b1, 1'b1, 1'b1);
    check("R9 switch wins over clear", 64'(cfg_out), 64'(prev));
    check("R9 no error on priority switch", 64'(sw_err), 64'd0);

    // constrained random loads mixed with stray requests
    for (int r = 0; r < 80; r++) begin
      int len;
      len = N + int'($urandom % 5) - 2;
      if ($urandom % 3 != 0) len = N;
      for (int i = 0; i < len; i++) begin
        while ($urandom % 4 == 0) cycle(1'b0, 1'($urandom), 1'b0, 1'b0);
        if ($urandom % 60 == 0) cycle(1'b1, 1'($urandom), 1'b0, 1'b1);
        cycle(1'b1, 1'($urandom), ($urandom % 80 == 0), 1'b0);
      end
      cycle(1'($urandom), 1'($urandom), 1'b1, 1'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule